// File: doc/BRIEF.md
# Embedded Controller Interface Register

This block is a single control/status register that sits on the embedded-processor side of a wireless MAC controller. Only the embedded core can read or write it; the host interface has no path to it. The register holds three live bits: a direct-access mode bit that tells the host-side memory logic whether its cycles go straight to the memory interface or through the arbitration path, a flash remap enable, and a sticky power-down request flag.

The power-down request flag is raised by the host side. It is set when the host writes a 1 to the power-down bit in the card configuration/status register, or to the power-down bit in a host-side system register. Each of these sources reaches the block as a write strobe plus the written bit value. While the flag is set, an interrupt goes to the embedded core. The core clears the flag by writing a 1 to its bit position.

The remap bit controls a flash address decoder. Flash is always visible in the top 128K of the core's 1M address space. When remap is on, the upper 96K of the flash also appears in a second window low in the address space. The decoder produces a flash select and the offset into the flash.

Top module: `ec_ctrl_reg`

## Requirements
- R1: After reset, read data is 0x00, the interrupt is low and the direct-mode output is low.
- R2: A core write loads bit 7 (direct access). The direct-mode output and read bit 7 show the written value from the next cycle on. A value of 1 means host cycles bypass arbitration.
- R3: A core write loads bit 6 (remap enable), which reads back from the next cycle on.
- R4: A write strobe on host source 0 (the card configuration power-down bit) that carries a bit value of 1 sets the request flag (read bit 5) on the next cycle. The same strobe with a bit value of 0 leaves the flag unchanged.
- R5: A write strobe on host source 1 (the system-register power-down bit) that carries a bit value of 1 sets the request flag on the next cycle. With a bit value of 0 it has no effect.
- R6: The interrupt output equals the request flag in every cycle.
- R7: A core write with bit 5 = 1 clears the flag on the next cycle. A core write with bit 5 = 0 leaves the flag unchanged.
- R8: When a host set event and a core clear happen in the same cycle, the flag ends up set.
- R9: Read bits 4:0 are always 0, whatever value was written to them.
- R10: Core addresses 0xE0000 to 0xFFFFF always select flash with offset = address − 0xE0000, whatever the remap bit holds.
- R11: With remap = 1, core addresses 0x08000 to 0x1FFFF select flash with offset equal to the address, which covers the top 96K of the 128K flash.
- R12: With remap = 0, the low window does not select flash. Addresses outside the enabled windows never select flash, and the offset then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreWr | input | 1 | Embedded-core write strobe for this register |
| coreWrData | input | 8 | Embedded-core write data |
| regRdData | output | 8 | Register contents as read by the core |
| hostPdWr | input | 2 | Host power-down write strobes (bit 0 card configuration, bit 1 system register) |
| hostPdBit | input | 2 | Power-down bit value carried by each strobe |
| coreIrq | output | 1 | Power-down request interrupt to the core |
| directMode | output | 1 | Host cycles bypass arbitration when high |
| coreAddr | input | 20 | Embedded-core memory address |
| flashSel | output | 1 | Current core address selects flash |
| flashOff | output | 17 | Byte offset into flash |

## Verification
The flag logic is swept over every combination of the starting flag value, both host strobes with their bit values, and a core write with bit 5 set or clear. This separates a setting source from a non-setting one, write-one-to-clear from write-zero, and the case where set and clear arrive together. The address decoder is swept across the whole address space in coarse steps, plus the address on each side of every window edge, with remap both off and on. The two remap settings separate the window that is always present from the switchable one, and the edge addresses catch an off-by-one in the window limits or an offset miscomputation. The control bits are written in all four combinations to show that they load independently of each other.

// File: rtl/ec_ctrl_pkg.sv
package ec_ctrl_pkg;

  // Bit positions decoded by neighbouring logic and firmware
  localparam int MODE_BIT  = 7;
  localparam int REMAP_BIT = 6;
  localparam int REQ_BIT   = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCtl;   // load mode and remap bits
    logic modeVal;
    logic remapVal;
    logic setReq;    // any host source requests power-down
    logic clrReq;    // core write-one-to-clear
  } ctlStrobe_t;

endpackage

// File: rtl/ec_ctrl_ctl.sv
module ec_ctrl_ctl
  import ec_ctrl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 2
) (
  input  logic              coreWr,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic [NUM_SRC-1:0] hostPdWr,
  input  logic [NUM_SRC-1:0] hostPdBit,
  output ctlStrobe_t        strobe
);

  logic [NUM_SRC-1:0] srcSet;
  logic unusedData;

  // One set term per host power-down source
  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
      assign srcSet[s] = hostPdWr[s] & hostPdBit[s];
    end
  endgenerate

  assign unusedData = ^coreWrData[REQ_BIT-1:0];

  always_comb begin
    strobe          = '0;
    strobe.loadCtl  = coreWr;
    strobe.modeVal  = coreWrData[MODE_BIT];
    strobe.remapVal = coreWrData[REMAP_BIT];
    strobe.setReq   = |srcSet;
    strobe.clrReq   = coreWr & coreWrData[REQ_BIT];
  end

endmodule

// File: rtl/ec_ctrl_dp.sv
module ec_ctrl_dp
  import ec_ctrl_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              ADDR_W   = 20,
  parameter int              FLASH_AW = 17,
  parameter logic [ADDR_W-1:0] HI_BASE = 20'hE0000,
  parameter logic [ADDR_W-1:0] LO_BASE = 20'h08000,
  parameter logic [ADDR_W-1:0] LO_LAST = 20'h1FFFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   coreAddr,
  output logic [DATA_W-1:0]   regRdData,
  output logic                coreIrq,
  output logic                directMode,
  output logic                flashSel,
  output logic [FLASH_AW-1:0] flashOff
);

  // Low window shows the top part of flash, so its first address
  // lands at flash size minus window size.
  localparam logic [ADDR_W-1:0] FLASH_BYTES = ADDR_W'(1) << FLASH_AW;
  localparam logic [ADDR_W-1:0] LO_BYTES    = LO_LAST - LO_BASE + 1'b1;
  localparam logic [ADDR_W-1:0] LO_SHIFT    = FLASH_BYTES - LO_BYTES;

  logic modeQ, remapQ, reqQ;
  logic hiHit, loHit;
  logic [FLASH_AW-1:0] hiOff, loOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      remapQ <= 1'b0;
      reqQ   <= 1'b0;
    end else begin
      if (strobe.loadCtl) begin
        modeQ  <= strobe.modeVal;
        remapQ <= strobe.remapVal;
      end
      // set beats clear so no request is lost
      if (strobe.setReq)      reqQ <= 1'b1;
      else if (strobe.clrReq) reqQ <= 1'b0;
    end
  end

  always_comb begin
    regRdData            = '0;
    regRdData[MODE_BIT]  = modeQ;
    regRdData[REMAP_BIT] = remapQ;
    regRdData[REQ_BIT]   = reqQ;
  end

  assign coreIrq    = reqQ;
  assign directMode = modeQ;

  assign hiHit = (coreAddr >= HI_BASE);
  assign loHit = remapQ && (coreAddr >= LO_BASE) && (coreAddr <= LO_LAST);
  assign hiOff = coreAddr[FLASH_AW-1:0] - HI_BASE[FLASH_AW-1:0];
  assign loOff = coreAddr[FLASH_AW-1:0] - LO_BASE[FLASH_AW-1:0]
               + LO_SHIFT[FLASH_AW-1:0];

  always_comb begin
    flashSel = hiHit | loHit;
    if (hiHit)      flashOff = hiOff;
    else if (loHit) flashOff = loOff;
    else            flashOff = '0;
  end

endmodule

// File: rtl/ec_ctrl_reg.sv
module ec_ctrl_reg
  import ec_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 20,
  parameter int FLASH_AW = 17,
  parameter int NUM_SRC  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                coreWr,
  input  logic [DATA_W-1:0]   coreWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_SRC-1:0]  hostPdWr,
  input  logic [NUM_SRC-1:0]  hostPdBit,
  output logic                coreIrq,
  output logic                directMode,
  input  logic [ADDR_W-1:0]   coreAddr,
  output logic                flashSel,
  output logic [FLASH_AW-1:0] flashOff
);

  ctlStrobe_t strobe;

  ec_ctrl_ctl #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) uCtl (
    .coreWr     (coreWr),
    .coreWrData (coreWrData),
    .hostPdWr   (hostPdWr),
    .hostPdBit  (hostPdBit),
    .strobe     (strobe)
  );

  ec_ctrl_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .coreAddr   (coreAddr),
    .regRdData  (regRdData),
    .coreIrq    (coreIrq),
    .directMode (directMode),
    .flashSel   (flashSel),
    .flashOff   (flashOff)
  );

endmodule

// File: rtl/ec_ctrl_chk.sv
module ec_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        coreWr,
  input logic [7:0]  coreWrData,
  input logic [7:0]  regRdData,
  input logic [1:0]  hostPdWr,
  input logic [1:0]  hostPdBit,
  input logic        coreIrq,
  input logic        directMode,
  input logic [19:0] coreAddr,
  input logic        flashSel
);

  logic anySet;
  assign anySet = |(hostPdWr & hostPdBit);

  // R6
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreIrq == regRdData[5]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    anySet |=> regRdData[5]);

  // R7
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anySet && coreWr && coreWrData[5]) |=> !regRdData[5]);

  // R4
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anySet && !(coreWr && coreWrData[5])) |=> $stable(regRdData[5]));

  // R9
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[4:0] == 5'd0);

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWr |=> directMode == $past(coreWrData[7]));

  // R10
  hi_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreAddr >= 20'hE0000) |-> flashSel);

endmodule

bind ec_ctrl_reg ec_ctrl_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .coreWr     (coreWr),
  .coreWrData (coreWrData),
  .regRdData  (regRdData),
  .hostPdWr   (hostPdWr),
  .hostPdBit  (hostPdBit),
  .coreIrq    (coreIrq),
  .directMode (directMode),
  .coreAddr   (coreAddr),
  .flashSel   (flashSel)
);

// File: tb/sim_ec_ctrl_reg.sv
`timescale 1ns/1ps
module sim_ec_ctrl_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coreWr = 1'b0;
  logic [7:0]  coreWrData = '0;
  logic [7:0]  regRdData;
  logic [1:0]  hostPdWr = '0;
  logic [1:0]  hostPdBit = '0;
  logic        coreIrq;
  logic        directMode;
  logic [19:0] coreAddr = '0;
  logic        flashSel;
  logic [16:0] flashOff;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ec_ctrl_reg u0 (
    .clk(clk), .rstN(rstN), .coreWr(coreWr), .coreWrData(coreWrData),
    .regRdData(regRdData), .hostPdWr(hostPdWr), .hostPdBit(hostPdBit),
    .coreIrq(coreIrq), .directMode(directMode), .coreAddr(coreAddr),
    .flashSel(flashSel), .flashOff(flashOff)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive just after a falling edge, let one rising edge pass
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic coreWrite(input logic [7:0] d);
    coreWr = 1'b1; coreWrData = d;
    tick();
    coreWr = 1'b0; coreWrData = '0;
  endtask

  task automatic checkAddr(input logic [19:0] a, input bit remap);
    logic expSel;
    logic [16:0] expOff;
    coreAddr = a;
    #1;
    if (a >= 20'hE0000) begin
      expSel = 1'b1; expOff = 17'(a - 20'hE0000);
    end else if (remap && a >= 20'h08000 && a <= 20'h1FFFF) begin
      expSel = 1'b1; expOff = 17'(a);
    end else begin
      expSel = 1'b0; expOff = '0;
    end
    check(a >= 20'hE0000 ? "R10 sel" : (remap ? "R11 sel" : "R12 sel"),
          32'(flashSel), 32'(expSel));
    check(a >= 20'hE0000 ? "R10 off" : (remap ? "R11 off" : "R12 off"),
          32'(flashOff), 32'(expOff));
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    check("R1 rd", 32'(regRdData), 32'h00);
    check("R1 irq", 32'(coreIrq), 32'h0);
    check("R1 mode", 32'(directMode), 32'h0);

    // R2 R3: all four control combinations, low bits written as ones (R9)
    for (int m = 0; m < 4; m++) begin
      coreWrite({m[1], m[0], 1'b0, 5'h1F});
      check("R2 mode", 32'(directMode), 32'(m[1]));
      check("R2 rd7", 32'(regRdData[7]), 32'(m[1]));
      check("R3 rd6", 32'(regRdData[6]), 32'(m[0]));
      check("R9 low", 32'(regRdData[4:0]), 32'h0);
    end
    coreWrite(8'h00);

    // R4 R5 R6 R7 R8: full sweep of flag inputs
    for (int v = 0; v < 128; v++) begin
      logic start, expF;
      start = v[6];
      if (start) begin
        hostPdWr = 2'b01; hostPdBit = 2'b01; tick();
      end else begin
        hostPdWr = 2'b00; hostPdBit = 2'b00;
        coreWr = 1'b1; coreWrData = 8'h20; tick();
      end
      hostPdWr = '0; hostPdBit = '0; coreWr = 1'b0; coreWrData = '0;
      hostPdWr  = v[1:0];
      hostPdBit = v[3:2];
      coreWr    = v[4];
      coreWrData = {2'b00, v[5], 5'h00};
      tick();
      hostPdWr = '0; hostPdBit = '0; coreWr = 1'b0; coreWrData = '0;
      expF = (v[0] & v[2]) | (v[1] & v[3]) | (start & ~(v[4] & v[5]));
      if ((v[0] & v[2]) | (v[1] & v[3]))
        check((v[4] & v[5]) ? "R8 set wins" : (v[0] & v[2]) ? "R4 set" : "R5 set",
              32'(regRdData[5]), 32'(expF));
      else
        check(v[4] ? "R7 core write" : "R4 R5 no set", 32'(regRdData[5]), 32'(expF));
      check("R6 irq", 32'(coreIrq), 32'(expF));
      check("R9 low", 32'(regRdData[4:0]), 32'h0);
    end

    // R10 R11 R12: address sweep with remap off and on
    for (int r = 0; r < 2; r++) begin
      coreWrite({1'b0, r[0], 6'h00});
      for (int a = 0; a < 32'h100000; a += 32'h400) checkAddr(20'(a), r[0]);
      checkAddr(20'h07FFF, r[0]); checkAddr(20'h08000, r[0]);
      checkAddr(20'h1FFFF, r[0]); checkAddr(20'h20000, r[0]);
      checkAddr(20'hDFFFF, r[0]); checkAddr(20'hE0000, r[0]);
      checkAddr(20'hFFFFF, r[0]); checkAddr(20'h00000, r[0]);
      @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule